// File: doc/BRIEF.md
# ADC Scan Sequencer with Sample FIFO

This block controls a 12-bit converter that sits behind an analog multiplexer. Software programs a window of channels, given as a first and a last channel, and a gain entry for each channel. It then enables one or more conversion sources. Each accepted trigger converts the channel the scan pointer currently holds. The result goes into a sample FIFO together with its channel number, and the pointer moves to the next channel in the window. After the last channel it returns to the first.

A host reads samples and status through a small 16-bit register port. The interrupt line can be set to fire after every stored sample, or only once the FIFO holds at least half its capacity. If a sample arrives while the FIFO is full, the sample is dropped and a sticky error flag is set. Only a flush of the FIFO clears that flag. The block contains no pacer counter, no analog front end and no bus bridge. Its sources are a one-cycle pacer tick, an external trigger pulse and a gate level.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control word is zero, the status register (offset 6) reads 0x0100 (only the empty flag set), and the interrupt output is low.
- R2: A write to offset 6 loads the 7-bit control word, which reads back in status bits 6:0. Its bit 6 drives the pacer clock-select output. A write to offset 4 sets the first channel (bits 7:0) and the last channel (bits 15:8), and both read back at offset 4.
- R3: A conversion starts only from an enabled source: a write to offset 0 when bit 0 is set, a pacer tick when bit 1 is set, or an external trigger pulse when bit 2 is set. When bit 3 is also set, a pacer tick counts only while the gate input is high.
- R4: Each conversion gives exactly one single-cycle start pulse. Any trigger that arrives before the converter reports done is ignored.
- R5: Each stored word holds the 12-bit result in bits 11:0 and the converted channel number in bits 15:12. Words leave the FIFO in arrival order through reads at offset 0.
- R6: The channel pointer advances by one after each finished conversion and goes back to the first channel after converting the last channel. This also holds for a window that wraps past channel 15. A write to offset 4 restarts the scan at the new first channel.
- R7: A write to offset 2 stores a gain entry for the current first channel: bits 2:0 are the gain code, bit 4 is the range group and bit 5 is the differential flag. Other bits are dropped. The entry reads back at offset 2, and during a conversion the entry of the converted channel appears on the gain outputs.
- R8: Status bit 8 is set when the FIFO is empty. Bit 9 is set when it holds at least half its depth. Bit 10 is set when it is full or an overrun has occurred. Bit 11 shows the pending interrupt.
- R9: A sample that arrives while the FIFO is full is dropped and does not replace stored data. The full flag then stays set, even after reads, until a flush.
- R10: A read at offset 0 while the FIFO is empty returns the last word popped and leaves the FIFO unchanged.
- R11: With interrupts enabled (bit 4) and bit 5 clear, every stored sample sets the pending interrupt. Any write to offset 8 clears it. With bit 4 clear, no interrupt is raised.
- R12: With bits 4 and 5 set, the interrupt is raised only by a stored sample that leaves the FIFO at least half full.
- R13: Any write to offset 9 empties the FIFO and clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read at offset 0 pops a sample) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the offset |
| pacer_tick | input | 1 | One-cycle pacer trigger |
| ext_trig | input | 1 | One-cycle external trigger |
| ext_gate | input | 1 | Gate level that qualifies pacer ticks |
| adc_start | output | 1 | Start-conversion pulse |
| adc_chan | output | 4 | Channel selected for the multiplexer |
| adc_gain_code | output | 3 | Gain code of the selected channel |
| adc_range_grp | output | 1 | Range group of the selected channel |
| adc_diff | output | 1 | Differential flag of the selected channel |
| adc_done | input | 1 | Converter reports that the result is valid |
| adc_result | input | 12 | Conversion result |
| pacer_clk_ext | output | 1 | Pacer clock-select bit from the control word |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle:
- start pulses last one cycle, only happen while a conversion is marked busy, and always follow an enabled source;
- the scan pointer never leaves the programmed window;
- the full flag cannot drop without a flush, and a flush always leaves the FIFO empty;
- a read from an empty FIFO never changes it;
- the interrupt rises only after a sample is stored with interrupts enabled.

Other behaviour needs the bench's scenarios. These cover the exact word layout and channel order across a wrapping window, and the gain entry presented for each channel. They also cover the half-full threshold of the interrupt, the dropping of samples on overrun, and the value returned by a read from an empty FIFO.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    // register offsets; the host's register map depends on them
    localparam int OFS_DATA   = 0;
    localparam int OFS_GAIN   = 2;
    localparam int OFS_SCAN   = 4;
    localparam int OFS_CSR    = 6;
    localparam int OFS_IRQCLR = 8;
    localparam int OFS_FLUSH  = 9;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic clk_sel;   // bit 6
        logic half_irq;  // bit 5
        logic irq_en;    // bit 4
        logic gate_en;   // bit 3
        logic ext_en;    // bit 2
        logic pacer_en;  // bit 1
        logic sw_en;     // bit 0
    } ctrl_t;

    typedef struct packed {
        logic       diff;
        logic       grp;
        logic [2:0] code;
    } gain_t;

endpackage

// File: rtl/gain_table.sv
module gain_table
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_idx,
    input  gain_t           wr_val,
    input  logic [CH_W-1:0] idx_a,
    input  logic [CH_W-1:0] idx_b,
    output gain_t           val_a,
    output gain_t           val_b
);
    localparam int NUM_CH = 1 << CH_W;

    typedef struct packed {
        gain_t [NUM_CH-1:0] ent;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ent[wr_idx] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign val_a = s_q.ent[idx_a];
    assign val_b = s_q.ent[idx_b];
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int CH_W  = 4,
    parameter int RES_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_en,
    input  logic                  pacer_en,
    input  logic                  ext_en,
    input  logic                  gate_en,
    input  logic                  sw_req,
    input  logic                  pacer_tick,
    input  logic                  ext_trig,
    input  logic                  ext_gate,
    input  logic                  restart,
    input  logic [CH_W-1:0]       restart_ch,
    input  logic [CH_W-1:0]       first_ch,
    input  logic [CH_W-1:0]       last_ch,
    input  logic                  adc_done,
    input  logic [RES_W-1:0]      adc_result,
    output logic                  adc_start,
    output logic                  busy,
    output logic [CH_W-1:0]       cur_ch,
    output logic                  smp_vld,
    output logic [CH_W+RES_W-1:0] smp_word
);
    localparam int WORD_W = CH_W + RES_W;

    typedef struct packed {
        logic              busy;
        logic              start;
        logic [CH_W-1:0]   ch;
        logic              vld;
        logic [WORD_W-1:0] word;
    } st_t;

    st_t  s_d, s_q;
    logic trig;

    assign trig = (sw_en & sw_req)
                | (pacer_en & pacer_tick & (~gate_en | ext_gate))
                | (ext_en & ext_trig);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.vld   = 1'b0;
        if (s_q.busy && adc_done) begin
            s_d.busy = 1'b0;
            s_d.vld  = 1'b1;
            s_d.word = {s_q.ch, adc_result};
            s_d.ch   = (s_q.ch == last_ch) ? first_ch : s_q.ch + CH_W'(1);
        end else if (!s_q.busy && trig) begin
            s_d.busy  = 1'b1;
            s_d.start = 1'b1;
        end
        if (restart) s_d.ch = restart_ch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign adc_start = s_q.start;
    assign busy      = s_q.busy;
    assign cur_ch    = s_q.ch;
    assign smp_vld   = s_q.vld;
    assign smp_word  = s_q.word;
endmodule

// File: rtl/scan_fifo.sv
module scan_fifo #(
    parameter int DEPTH = 4096,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         half,
    output logic         full,
    output logic         stored,
    output logic         half_next
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic         at_top, do_push, do_pop;

    assign at_top  = (s_q.cnt == CW'(DEPTH));
    assign do_push = push && !at_top && !clr;
    assign do_pop  = pop && (s_q.cnt != '0) && !clr;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = s_q.wp + AW'(1);
            if (do_pop)  s_d.rp = s_q.rp + AW'(1);
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
            if (push && at_top) s_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wp] <= wdata;
    end

    assign head      = mem[s_q.rp];
    assign empty     = (s_q.cnt == '0);
    assign half      = (s_q.cnt >= CW'(HALF));
    assign full      = at_top | s_q.ovr;
    assign stored    = do_push;
    assign half_next = (s_d.cnt >= CW'(HALF));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int FIFO_DEPTH = 4096,
    parameter int CH_W       = 4,
    parameter int RES_W      = 12,
    parameter int ADDR_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CH_W+RES_W-1:0] bus_wdata,
    output logic [CH_W+RES_W-1:0] bus_rdata,
    input  logic                  pacer_tick,
    input  logic                  ext_trig,
    input  logic                  ext_gate,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_chan,
    output logic [2:0]            adc_gain_code,
    output logic                  adc_range_grp,
    output logic                  adc_diff,
    input  logic                  adc_done,
    input  logic [RES_W-1:0]      adc_result,
    output logic                  pacer_clk_ext,
    output logic                  irq
);
    localparam int WORD_W = CH_W + RES_W;
    localparam int HI_FLD = 8;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CH_W-1:0]   first;
        logic [CH_W-1:0]   last;
        logic              irq;
        logic [WORD_W-1:0] held;
    } st_t;

    st_t s_d, s_q;

    logic sw_req, pop_req, gain_wr, scan_wr, csr_wr, irq_clr, flush;
    logic seq_busy, smp_vld;
    logic [CH_W-1:0] cur_ch;
    logic [WORD_W-1:0] smp_word, fifo_head;
    logic fifo_empty, fifo_half, fifo_full, fifo_stored, fifo_half_next;
    gain_t g_cur, g_first;
    ctrl_t ctrl;
    logic [CH_W-1:0] first_ch, last_ch;
    logic wdata_unused;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign sw_req  = bus_wr && hit(bus_addr, OFS_DATA);
    assign gain_wr = bus_wr && hit(bus_addr, OFS_GAIN);
    assign scan_wr = bus_wr && hit(bus_addr, OFS_SCAN);
    assign csr_wr  = bus_wr && hit(bus_addr, OFS_CSR);
    assign irq_clr = bus_wr && hit(bus_addr, OFS_IRQCLR);
    assign flush   = bus_wr && hit(bus_addr, OFS_FLUSH);
    assign pop_req = bus_rd && hit(bus_addr, OFS_DATA);
    assign wdata_unused = ^bus_wdata;

    assign ctrl     = s_q.ctrl;
    assign first_ch = s_q.first;
    assign last_ch  = s_q.last;

    gain_table #(.CH_W(CH_W)) u_gain (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (gain_wr),
        .wr_idx (s_q.first),
        .wr_val ({bus_wdata[5], bus_wdata[4], bus_wdata[2:0]}),
        .idx_a  (cur_ch),
        .idx_b  (s_q.first),
        .val_a  (g_cur),
        .val_b  (g_first)
    );

    scan_seq #(.CH_W(CH_W), .RES_W(RES_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_en      (s_q.ctrl.sw_en),
        .pacer_en   (s_q.ctrl.pacer_en),
        .ext_en     (s_q.ctrl.ext_en),
        .gate_en    (s_q.ctrl.gate_en),
        .sw_req     (sw_req),
        .pacer_tick (pacer_tick),
        .ext_trig   (ext_trig),
        .ext_gate   (ext_gate),
        .restart    (scan_wr),
        .restart_ch (bus_wdata[CH_W-1:0]),
        .first_ch   (s_q.first),
        .last_ch    (s_q.last),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .adc_start  (adc_start),
        .busy       (seq_busy),
        .cur_ch     (cur_ch),
        .smp_vld    (smp_vld),
        .smp_word   (smp_word)
    );

    scan_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push      (smp_vld),
        .wdata     (smp_word),
        .pop       (pop_req),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .half      (fifo_half),
        .full      (fifo_full),
        .stored    (fifo_stored),
        .half_next (fifo_half_next)
    );

    always_comb begin
        s_d = s_q;
        if (csr_wr) s_d.ctrl = ctrl_t'(bus_wdata[6:0]);
        if (scan_wr) begin
            s_d.first = bus_wdata[CH_W-1:0];
            s_d.last  = bus_wdata[HI_FLD +: CH_W];
        end
        if (pop_req && !fifo_empty) s_d.held = fifo_head;
        if (irq_clr) s_d.irq = 1'b0;
        if (fifo_stored && s_q.ctrl.irq_en && (!s_q.ctrl.half_irq || fifo_half_next))
            s_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_DATA)) begin
            bus_rdata = fifo_empty ? s_q.held : fifo_head;
        end else if (hit(bus_addr, OFS_GAIN)) begin
            bus_rdata[2:0] = g_first.code;
            bus_rdata[4]   = g_first.grp;
            bus_rdata[5]   = g_first.diff;
        end else if (hit(bus_addr, OFS_SCAN)) begin
            bus_rdata[CH_W-1:0]       = s_q.first;
            bus_rdata[HI_FLD +: CH_W] = s_q.last;
        end else if (hit(bus_addr, OFS_CSR)) begin
            bus_rdata[6:0] = s_q.ctrl;
            bus_rdata[8]   = fifo_empty;
            bus_rdata[9]   = fifo_half;
            bus_rdata[10]  = fifo_full;
            bus_rdata[11]  = s_q.irq;
        end
    end

    assign adc_chan      = cur_ch;
    assign adc_gain_code = g_cur.code;
    assign adc_range_grp = g_cur.grp;
    assign adc_diff      = g_cur.diff;
    assign pacer_clk_ext = s_q.ctrl.clk_sel;
    assign irq           = s_q.irq;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adc_start,
    input logic            busy,
    input ctrl_t           ctrl,
    input logic            fifo_empty,
    input logic            fifo_full,
    input logic            fifo_stored,
    input logic            flush,
    input logic            smp_vld,
    input logic            pop_req,
    input logic            irq_clr,
    input logic            irq,
    input logic [CH_W-1:0] cur_ch,
    input logic [CH_W-1:0] first_ch,
    input logic [CH_W-1:0] last_ch
);
    a_r4_start_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> busy);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    a_r3_source_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(ctrl.sw_en | ctrl.pacer_en | ctrl.ext_en));

    a_r6_chan_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ch <= last_ch) ? (cur_ch >= first_ch && cur_ch <= last_ch)
                              : (cur_ch >= first_ch || cur_ch <= last_ch));

    a_r9_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !flush) |=> fifo_full);

    a_r13_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_empty && !fifo_full));

    a_r10_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fifo_empty && !smp_vld) |=> fifo_empty);

    a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fifo_stored && ctrl.irq_en));

    a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fifo_stored) |=> !irq);
endmodule

bind adc_scan_ctrl adc_scan_chk #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_start   (adc_start),
    .busy        (seq_busy),
    .ctrl        (ctrl),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .fifo_stored (fifo_stored),
    .flush       (flush),
    .smp_vld     (smp_vld),
    .pop_req     (pop_req),
    .irq_clr     (irq_clr),
    .irq         (irq),
    .cur_ch      (cur_ch),
    .first_ch    (first_ch),
    .last_ch     (last_ch)
);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pacer_tick = 1'b0, ext_trig = 1'b0, ext_gate = 1'b0;
    logic        adc_start, adc_range_grp, adc_diff, pacer_clk_ext, irq;
    logic [3:0]  adc_chan;
    logic [2:0]  adc_gain_code;
    logic        adc_done = 1'b0;
    logic [11:0] adc_result = '0;

    int n_checks = 0, n_fail = 0;
    int starts = 0, seqno = 0, exp_cnt = 0;
    int exp_ch = 0, win_lo = 0, win_hi = 0;
    logic [4:0]  g_seen = '0;
    logic [15:0] expq[$];
    logic [15:0] last_popped = '0;
    logic [15:0] rv;

    adc_scan_ctrl #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
        .adc_start(adc_start), .adc_chan(adc_chan), .adc_gain_code(adc_gain_code),
        .adc_range_grp(adc_range_grp), .adc_diff(adc_diff), .adc_done(adc_done),
        .adc_result(adc_result), .pacer_clk_ext(pacer_clk_ext), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_scan(input int lo, input int hi);
        wr(4, (hi << 8) | lo);
        win_lo = lo; win_hi = hi; exp_ch = lo;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic sw_conv();
        wr(0, 0);
        settle();
    endtask

    task automatic flush_all();
        wr(9, 0);
        expq.delete();
        exp_cnt = 0;
    endtask

    // monitor side of the scoreboard: pop the FIFO and compare with the queue
    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [15:0] e;
            rd(0, rv);
            e = (expq.size() > 0) ? expq.pop_front() : 16'hxxxx;
            exp_cnt--;
            last_popped = rv;
            check(rv === e, req, rv, e);
        end
    endtask

    // converter model and driver side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start === 1'b1) begin
                logic [11:0] res;
                starts++;
                g_seen = {adc_diff, adc_range_grp, adc_gain_code};
                check(adc_chan == 4'(exp_ch), "R6 scan channel", adc_chan, exp_ch);
                res = 12'((seqno * 353 + 77) & 12'hfff);
                seqno++;
                if (exp_cnt < DEPTH) begin
                    expq.push_back({4'(exp_ch), res});
                    exp_cnt++;
                end
                exp_ch = (exp_ch == win_hi) ? win_lo : (exp_ch + 1) % 16;
                repeat (2) @(negedge clk);
                adc_done = 1'b1; adc_result = res;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6, rv);
        check(rv == 16'h0100, "R1 status after reset", rv, 16'h0100);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R2 control and scan readback
        wr(6, 16'h0041);
        rd(6, rv);
        check(rv[6:0] == 7'h41, "R2 control readback", rv[6:0], 7'h41);
        check(pacer_clk_ext == 1'b1, "R2 clock select output", pacer_clk_ext, 1);
        set_scan(3, 6);
        rd(4, rv);
        check(rv == 16'h0603, "R2 scan window readback", rv, 16'h0603);

        // R3 disabled sources do nothing
        wr(6, 0);
        s0 = starts;
        wr(0, 0); settle();
        @(negedge clk) pacer_tick = 1'b1; @(negedge clk) pacer_tick = 1'b0;
        @(negedge clk) ext_trig = 1'b1;   @(negedge clk) ext_trig = 1'b0;
        settle();
        check(starts == s0, "R3 no source enabled", starts, s0);
        wr(6, 1);
        sw_conv();
        check(starts == s0 + 1, "R3 software trigger", starts, s0 + 1);
        // R3 gated pacer
        wr(6, 16'h000A);
        ext_gate = 1'b0;
        @(negedge clk) pacer_tick = 1'b1; @(negedge clk) pacer_tick = 1'b0;
        settle();
        check(starts == s0 + 1, "R3 pacer blocked by gate", starts, s0 + 1);
        ext_gate = 1'b1;
        @(negedge clk) pacer_tick = 1'b1; @(negedge clk) pacer_tick = 1'b0;
        settle();
        check(starts == s0 + 2, "R3 pacer with gate high", starts, s0 + 2);
        wr(6, 4);
        @(negedge clk) ext_trig = 1'b1; @(negedge clk) ext_trig = 1'b0;
        settle();
        check(starts == s0 + 3, "R3 external trigger", starts, s0 + 3);

        // R4 trigger during conversion ignored
        wr(6, 1);
        s0 = starts;
        wr(0, 0); wr(0, 0); settle();
        check(starts == s0 + 1, "R4 busy trigger ignored", starts, s0 + 1);

        // R5 R6 word layout and wrapping window
        flush_all();
        set_scan(14, 1);
        for (int i = 0; i < 6; i++) sw_conv();
        drain(6, "R5 word and order, wrapping window");
        set_scan(2, 4);
        sw_conv(); sw_conv();
        set_scan(2, 4);
        sw_conv();
        drain(3, "R6 restart on scan write");

        // R7 gain table
        set_scan(5, 5); wr(2, 16'h0035);
        set_scan(6, 6); wr(2, 16'h0002);
        set_scan(7, 7); wr(2, 16'hFFFF);
        rd(2, rv);
        check(rv == 16'h0037, "R7 unused gain bits dropped", rv, 16'h0037);
        set_scan(5, 5);
        rd(2, rv);
        check(rv == 16'h0035, "R7 gain readback", rv, 16'h0035);
        set_scan(5, 6);
        sw_conv();
        check(g_seen == 5'b11101, "R7 gain outputs ch5", g_seen, 5'b11101);
        sw_conv();
        check(g_seen == 5'b00010, "R7 gain outputs ch6", g_seen, 5'b00010);
        drain(2, "R7 samples");

        // R11 every-sample interrupt
        flush_all(); wr(8, 0);
        wr(6, 16'h0001);
        sw_conv();
        check(irq == 1'b0, "R11 no irq when disabled", irq, 0);
        wr(6, 16'h0011);
        sw_conv();
        check(irq == 1'b1, "R11 irq per sample", irq, 1);
        rd(6, rv);
        check(rv[11:8] == 4'b1000, "R8 status with two samples", rv[11:8], 4'b1000);
        wr(8, 0);
        check(irq == 1'b0, "R11 irq cleared by write", irq, 0);

        // R12 half-full interrupt
        flush_all(); wr(8, 0);
        set_scan(0, 15);
        wr(6, 16'h0031);
        for (int i = 0; i < 7; i++) sw_conv();
        check(irq == 1'b0, "R12 no irq below half", irq, 0);
        rd(6, rv);
        check(rv[9] == 1'b0, "R8 half flag below half", rv[9], 0);
        sw_conv();
        check(irq == 1'b1, "R12 irq at half", irq, 1);
        rd(6, rv);
        check(rv[9] == 1'b1, "R8 half flag at half", rv[9], 1);

        // R9 overrun
        for (int i = 0; i < 8; i++) sw_conv();
        rd(6, rv);
        check(rv[10:8] == 3'b110, "R8 full flag at depth", rv[10:8], 3'b110);
        sw_conv(); sw_conv();
        drain(DEPTH, "R9 stored data kept on overrun");
        rd(6, rv);
        check(rv[10:8] == 3'b101, "R9 full sticky after drain", rv[10:8], 3'b101);

        // R10 empty read
        rd(0, rv);
        check(rv == last_popped, "R10 empty read returns last word", rv, last_popped);
        rd(6, rv);
        check(rv[8] == 1'b1, "R10 still empty", rv[8], 1);

        // R13 flush
        sw_conv(); sw_conv();
        flush_all();
        rd(6, rv);
        check(rv[10:8] == 3'b001, "R13 flush empties and clears full", rv[10:8], 3'b001);
        sw_conv();
        drain(1, "R13 data after flush");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule